// File: doc/BRIEF.md
# CCD exposure and readout timing controller

This block sets the frame-level exposure of a progressive-scan CCD. It runs on the pixel-rate clock and follows two active-low sync inputs, a horizontal sync that starts each line and a vertical sync that marks the end of a frame. Two outputs result. The active-low discharge pulse `xsub_n` empties the sensor, and its last rising edge starts the exposure. The active-low transfer pulse `xsg_n` moves the charge out, and its rising edge ends the exposure. A line flag `wen` tells the downstream capture logic which lines carry image data.

There are four shutter modes. With the shutter off, the block reads out once per frame and never discharges. In line mode, the exposure lasts a programmed number of line periods plus a fixed tail of clocks. Flickerless mode is line mode with a built-in line count equal to three fifths of a frame, which gives 1/50 s at 30 frames/s. In frame mode, charge builds up over several frames before a single readout. The mode and the count are taken in at the start of each frame. A standby input forces both pulses inactive and clears the line flag, but the timing counters keep running. All inputs are treated as synchronous to `clk`, and every output is registered.

The timing is defined from the detected horizontal sync. Pixel index 0 is the clock after `hsync_n` is first sampled low. A line index is held for each line, and line 0 is the readout line. Each output appears one clock after the pixel and line state that produces it.

Top module: `ccd_exposure_timing`

## Requirements
- R1: Reset drives `xsub_n` = 1, `xsg_n` = 1 and `wen` = 0, and no readout happens before the first detected frame.
- R2: A high-to-low change of `hsync_n` starts a line and resets the pixel index to 0. The vertical sync is read at pixel indices WIN_START to WIN_START+WIN_LEN-1, and it counts as low if it is low at any of those samples. If one line reads it low and the line before read it high, the next line becomes line 0 of a new frame.
- R3: Any low level on `vsync_n` outside the pixel window has no effect on the frame timing.
- R4: On line 0 of a readout frame, `xsg_n` is low for exactly XSG_W clocks, starting at pixel XSG_POS.
- R5: In line mode (`shut_mode` = 1), `xsub_n` pulses low for XSUB_W clocks once per line on lines 1 through the last discharge line. That line is placed so that the rising edge of the last `xsub_n` pulse comes exactly N×LINE_CLKS + TAIL_CLKS clocks before the next rising edge of `xsg_n`. `xsub_n` and `xsg_n` are never low together.
- R6: In line mode, a count below 2 is used as 2 and a count above FRAME_LINES-2 is used as FRAME_LINES-2.
- R7: With the shutter off (`shut_mode` = 0), `xsub_n` stays high and `xsg_n` pulses once in every frame.
- R8: In flickerless mode (`shut_mode` = 3), the block behaves as line mode with N = FRAME_LINES×3/5 and ignores `exp_count`.
- R9: In frame mode (`shut_mode` = 2), `xsub_n` stays high and `xsg_n` pulses once every F frames, where F is `exp_count` limited to the range 2 to 2^CNT_W-2.
- R10: A change of `shut_mode` or `exp_count` in the middle of a frame first takes effect at the next frame start.
- R11: With `wm` = 0, `wen` is high exactly on lines VALID_FIRST to VALID_LAST of a frame whose line 0 carried a readout.
- R12: With `wm` = 1, `wen` goes high together with the falling edge of `xsg_n` and stays high until the next frame's line 0 begins.
- R13: One clock after `stdby_n` is sampled low, `xsub_n` and `xsg_n` are high and `wen` is low, and they stay so while standby lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, falling edge starts a line |
| vsync_n | input | 1 | Vertical sync level, read only inside the line window |
| stdby_n | input | 1 | Low forces the standby output levels |
| wm | input | 1 | Line flag mode: 0 valid-line window, 1 follows readout |
| shut_mode | input | 2 | 0 off, 1 line count, 2 frame count, 3 flickerless |
| exp_count | input | CNT_W | Exposure lines (mode 1) or frames (mode 2) |
| xsub_n | output | 1 | Active-low discharge pulse |
| xsg_n | output | 1 | Active-low readout pulse |
| wen | output | 1 | Line write-enable flag |

## Verification
Standby and readout can meet in one clock: `stdby_n` may fall while `xsg_n` is already low. The bench waits until it sees `xsg_n` low, then drops standby on the next falling clock edge. On the following sample it expects `xsg_n` high, with the pulse cut short and not finished. A second pair can also meet: a count written in the middle of a frame while discharge pulses are running. The bench writes the count after line 2 has begun and expects the current frame to keep its old count of discharge pulses and its old exposure. It expects the new count to show only in the frame after.

// File: rtl/ccd_exp_pkg.sv
package ccd_exp_pkg;

  typedef enum logic [1:0] {
    SHUT_OFF     = 2'd0,
    SHUT_LINES   = 2'd1,
    SHUT_FRAMES  = 2'd2,
    SHUT_FLICKER = 2'd3
  } shut_mode_e;

endpackage

// File: rtl/ccd_line_sync.sv
module ccd_line_sync #(
  parameter int WIN_START   = 40,
  parameter int WIN_LEN     = 8,
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_n,
  input  logic              vsync_n,
  output logic [PIX_W-1:0]  pix_idx,
  output logic [LINE_W-1:0] line_idx,
  output logic              frame_start
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [PIX_W-1:0]  WIN_LO   = PIX_W'(WIN_START);
  localparam logic [PIX_W-1:0]  WIN_HI   = PIX_W'(WIN_START + WIN_LEN - 1);

  logic hd_q;
  logic vd_win;
  logic vd_prev;
  logic line_start;
  logic in_win;

  assign line_start  = hd_q & ~hsync_n;
  assign in_win      = (pix_idx >= WIN_LO) && (pix_idx <= WIN_HI);
  assign frame_start = line_start & vd_prev & ~vd_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q     <= 1'b1;
      vd_win   <= 1'b1;
      vd_prev  <= 1'b1;
      pix_idx  <= PIX_MAX;
      line_idx <= LINE_MAX;
    end else begin
      hd_q <= hsync_n;
      if (line_start) begin
        pix_idx <= '0;
        vd_prev <= vd_win;
        if (frame_start) begin
          line_idx <= '0;
        end else if (line_idx != LINE_MAX) begin
          line_idx <= line_idx + 1'b1;
        end
      end else begin
        if (pix_idx != PIX_MAX) begin
          pix_idx <= pix_idx + 1'b1;
        end
        if (in_win) begin
          if (pix_idx == WIN_LO) begin
            vd_win <= vsync_n;
          end else begin
            vd_win <= vd_win & vsync_n;
          end
        end
      end
    end
  end

endmodule

// File: rtl/ccd_expo_sched.sv
module ccd_expo_sched
  import ccd_exp_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int TAIL_CLKS   = 456,
  parameter int XSG_POS     = 600,
  parameter int XSG_W       = 40,
  parameter int XSUB_W      = 40,
  parameter int CNT_W       = 10,
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_idx,
  input  logic [LINE_W-1:0] line_idx,
  input  logic              frame_start,
  input  shut_mode_e        shut_mode,
  input  logic [CNT_W-1:0]  exp_count,
  output logic              xsub_act,
  output logic              xsg_act
);

  localparam int XSG_END    = XSG_POS + XSG_W;
  localparam int BACK       = (XSG_END >= TAIL_CLKS) ? 0 : 1;
  localparam int SUB_RISE   = XSG_END - TAIL_CLKS + BACK * LINE_CLKS;
  localparam int SUB_START  = SUB_RISE - XSUB_W;
  localparam int CMP_W      = ((CNT_W > LINE_W) ? CNT_W : LINE_W) + 1;

  localparam logic [PIX_W-1:0] XSG_LO = PIX_W'(XSG_POS);
  localparam logic [PIX_W-1:0] XSG_HI = PIX_W'(XSG_END - 1);
  localparam logic [PIX_W-1:0] SUB_LO = PIX_W'(SUB_START);
  localparam logic [PIX_W-1:0] SUB_HI = PIX_W'(SUB_RISE - 1);

  localparam logic [CNT_W-1:0] LMIN_C  = CNT_W'(2);
  localparam logic [CNT_W-1:0] LMAX_C  = CNT_W'(FRAME_LINES - 2);
  localparam logic [CNT_W-1:0] FLICK_C = CNT_W'(FRAME_LINES * 3 / 5);
  localparam logic [CNT_W-1:0] FMIN_C  = CNT_W'(2);
  localparam logic [CNT_W-1:0] FMAX_C  = CNT_W'((1 << CNT_W) - 2);
  localparam logic [CMP_W-1:0] LAST_BASE = CMP_W'(FRAME_LINES - BACK);

  shut_mode_e       mode_q;
  logic [CNT_W-1:0] lines_q;
  logic [CNT_W-1:0] acc_q;
  logic             rd_frame;
  logic [CNT_W-1:0] lines_cl;
  logic [CNT_W-1:0] frames_cl;
  logic [CMP_W-1:0] last_line;
  logic [CMP_W-1:0] line_ext;
  logic             sub_mode;
  logic             sub_line;
  logic             sub_pix;
  logic             xsg_pix;

  always_comb begin
    if (exp_count < LMIN_C) begin
      lines_cl = LMIN_C;
    end else if (exp_count > LMAX_C) begin
      lines_cl = LMAX_C;
    end else begin
      lines_cl = exp_count;
    end
    if (exp_count < FMIN_C) begin
      frames_cl = FMIN_C;
    end else if (exp_count > FMAX_C) begin
      frames_cl = FMAX_C;
    end else begin
      frames_cl = exp_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SHUT_OFF;
      lines_q  <= LMIN_C;
      acc_q    <= '0;
      rd_frame <= 1'b0;
    end else if (frame_start) begin
      mode_q  <= shut_mode;
      lines_q <= (shut_mode == SHUT_FLICKER) ? FLICK_C : lines_cl;
      if (shut_mode == SHUT_FRAMES) begin
        if (acc_q >= frames_cl - CNT_W'(1)) begin
          acc_q    <= '0;
          rd_frame <= 1'b1;
        end else begin
          acc_q    <= acc_q + 1'b1;
          rd_frame <= 1'b0;
        end
      end else begin
        acc_q    <= '0;
        rd_frame <= 1'b1;
      end
    end
  end

  assign last_line = LAST_BASE - CMP_W'(lines_q);
  assign line_ext  = CMP_W'(line_idx);
  assign sub_mode  = (mode_q == SHUT_LINES) || (mode_q == SHUT_FLICKER);
  assign sub_line  = (line_ext >= CMP_W'(1)) && (line_ext <= last_line);
  assign sub_pix   = (pix_idx >= SUB_LO) && (pix_idx <= SUB_HI);
  assign xsg_pix   = (pix_idx >= XSG_LO) && (pix_idx <= XSG_HI);

  assign xsub_act = sub_mode && sub_line && sub_pix;
  assign xsg_act  = rd_frame && (line_idx == '0) && xsg_pix;

endmodule

// File: rtl/ccd_expo_drive.sv
module ccd_expo_drive #(
  parameter int VALID_FIRST = 8,
  parameter int VALID_LAST  = 501,
  parameter int LINE_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stdby_n,
  input  logic              wm,
  input  logic              xsub_act,
  input  logic              xsg_act,
  input  logic              frame_start,
  input  logic [LINE_W-1:0] line_idx,
  output logic              xsub_n,
  output logic              xsg_n,
  output logic              wen
);

  localparam logic [LINE_W-1:0] VF_L = LINE_W'(VALID_FIRST);
  localparam logic [LINE_W-1:0] VL_L = LINE_W'(VALID_LAST);

  logic live;
  logic valid_line;
  logic wen_d;

  assign valid_line = (line_idx >= VF_L) && (line_idx <= VL_L);
  assign wen_d      = wm ? (live | xsg_act) : (live & valid_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0;
    end else if (frame_start) begin
      live <= 1'b0;
    end else if (xsg_act) begin
      live <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xsub_n <= 1'b1;
      xsg_n  <= 1'b1;
      wen    <= 1'b0;
    end else begin
      xsub_n <= ~(stdby_n & xsub_act);
      xsg_n  <= ~(stdby_n & xsg_act);
      wen    <= stdby_n & wen_d;
    end
  end

endmodule

// File: rtl/ccd_exposure_timing.sv
module ccd_exposure_timing
  import ccd_exp_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int TAIL_CLKS   = 456,
  parameter int XSG_POS     = 600,
  parameter int XSG_W       = 40,
  parameter int XSUB_W      = 40,
  parameter int WIN_START   = 40,
  parameter int WIN_LEN     = 8,
  parameter int VALID_FIRST = 8,
  parameter int VALID_LAST  = 501,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_n,
  input  logic             vsync_n,
  input  logic             stdby_n,
  input  logic             wm,
  input  logic [1:0]       shut_mode,
  input  logic [CNT_W-1:0] exp_count,
  output logic             xsub_n,
  output logic             xsg_n,
  output logic             wen
);

  localparam int PIX_W  = $clog2(LINE_CLKS) + 1;
  localparam int LINE_W = $clog2(FRAME_LINES) + 1;

  logic [PIX_W-1:0]  pix_idx;
  logic [LINE_W-1:0] line_idx;
  logic              frame_start;
  logic              xsub_act;
  logic              xsg_act;
  shut_mode_e        mode_in;

  assign mode_in = shut_mode_e'(shut_mode);

  ccd_line_sync #(
    .WIN_START (WIN_START),
    .WIN_LEN   (WIN_LEN),
    .PIX_W     (PIX_W),
    .LINE_W    (LINE_W)
  ) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .pix_idx     (pix_idx),
    .line_idx    (line_idx),
    .frame_start (frame_start)
  );

  ccd_expo_sched #(
    .LINE_CLKS   (LINE_CLKS),
    .FRAME_LINES (FRAME_LINES),
    .TAIL_CLKS   (TAIL_CLKS),
    .XSG_POS     (XSG_POS),
    .XSG_W       (XSG_W),
    .XSUB_W      (XSUB_W),
    .CNT_W       (CNT_W),
    .PIX_W       (PIX_W),
    .LINE_W      (LINE_W)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_idx     (pix_idx),
    .line_idx    (line_idx),
    .frame_start (frame_start),
    .shut_mode   (mode_in),
    .exp_count   (exp_count),
    .xsub_act    (xsub_act),
    .xsg_act     (xsg_act)
  );

  ccd_expo_drive #(
    .VALID_FIRST (VALID_FIRST),
    .VALID_LAST  (VALID_LAST),
    .LINE_W      (LINE_W)
  ) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .stdby_n     (stdby_n),
    .wm          (wm),
    .xsub_act    (xsub_act),
    .xsg_act     (xsg_act),
    .frame_start (frame_start),
    .line_idx    (line_idx),
    .xsub_n      (xsub_n),
    .xsg_n       (xsg_n),
    .wen         (wen)
  );

endmodule

// File: rtl/ccd_exposure_timing_chk.sv
module ccd_exposure_timing_chk #(
  parameter int XSG_W       = 40,
  parameter int VALID_FIRST = 8,
  parameter int VALID_LAST  = 501,
  parameter int LINE_W      = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stdby_n,
  input logic              wm,
  input logic              xsub_n,
  input logic              xsg_n,
  input logic              wen,
  input logic              frame_start,
  input logic [LINE_W-1:0] line_idx
);

  localparam int RUN_W = $clog2(XSG_W + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!xsg_n) begin
      if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
    end
  end

  AST_XSG_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RUN_W'(XSG_W)); // R4

  AST_XSG_ON_READOUT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xsg_n) |-> ($past(line_idx) == '0)); // R4

  AST_FRAME_RESTARTS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_idx == '0)); // R2

  AST_NO_PULSE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xsub_n && !xsg_n)); // R5

  AST_WEN_VALID_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && !$past(wm)) |-> (($past(line_idx) >= LINE_W'(VALID_FIRST)) &&
                             ($past(line_idx) <= LINE_W'(VALID_LAST)))); // R11

  AST_STDBY_XSG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !stdby_n |=> xsg_n); // R13

  AST_STDBY_XSUB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !stdby_n |=> xsub_n); // R13

  AST_STDBY_WEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !stdby_n |=> !wen); // R13

endmodule

bind ccd_exposure_timing ccd_exposure_timing_chk #(
  .XSG_W       (XSG_W),
  .VALID_FIRST (VALID_FIRST),
  .VALID_LAST  (VALID_LAST),
  .LINE_W      (LINE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stdby_n     (stdby_n),
  .wm          (wm),
  .xsub_n      (xsub_n),
  .xsg_n       (xsg_n),
  .wen         (wen),
  .frame_start (frame_start),
  .line_idx    (line_idx)
);

// File: tb/ccd_exposure_timing_test.sv
module ccd_exposure_timing_test;

  localparam int LC    = 48;
  localparam int FL    = 10;
  localparam int TAIL  = 20;
  localparam int XPOS  = 30;
  localparam int XW    = 6;
  localparam int SW    = 4;
  localparam int VF    = 2;
  localparam int VL    = 8;
  localparam int CW    = 10;
  localparam int FRAME = LC * FL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsync_n = 1'b1;
  logic          vsync_n = 1'b1;
  logic          stdby_n = 1'b1;
  logic          wm = 1'b0;
  logic [1:0]    shut_mode = 2'd0;
  logic [CW-1:0] exp_count = CW'(4);
  logic          xsub_n;
  logic          xsg_n;
  logic          wen;

  bit glitch_en = 1'b0;

  int checks = 0;
  int errors = 0;

  int cyc = 0;
  int t_sub_rise = 0;
  int t_xsg_fall = 0;
  int interval = 0;
  int exp_meas = 0;
  int nsub = 0;
  int sub_last = 0;
  int wen_acc = 0;
  int wen_last = 0;
  int xsg_rises = 0;
  int width_bad = 0;
  logic p_xsub = 1'b1;
  logic p_xsg = 1'b1;

  always #4 clk = ~clk;

  ccd_exposure_timing #(
    .LINE_CLKS   (LC),
    .FRAME_LINES (FL),
    .TAIL_CLKS   (TAIL),
    .XSG_POS     (XPOS),
    .XSG_W       (XW),
    .XSUB_W      (SW),
    .WIN_START   (2),
    .WIN_LEN     (4),
    .VALID_FIRST (VF),
    .VALID_LAST  (VL),
    .CNT_W       (CW)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .stdby_n   (stdby_n),
    .wm        (wm),
    .shut_mode (shut_mode),
    .exp_count (exp_count),
    .xsub_n    (xsub_n),
    .xsg_n     (xsg_n),
    .wen       (wen)
  );

  // sync generator: HD low for 2 clocks per line, VD low over the last line
  initial begin
    forever begin
      for (int l = 0; l < FL; l++) begin
        for (int p = 0; p < LC; p++) begin
          @(negedge clk);
          hsync_n = (p >= 2);
          vsync_n = !(l == FL - 1);
          if (glitch_en && l == 4 && p >= 20 && p < 24) vsync_n = 1'b0;
        end
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (p_xsub && !xsub_n) nsub = nsub + 1;
    if (!p_xsub && xsub_n) t_sub_rise = cyc;
    if (p_xsg && !xsg_n) begin
      interval   = cyc - t_xsg_fall;
      t_xsg_fall = cyc;
      wen_last   = wen_acc;
      wen_acc    = 0;
    end
    if (!p_xsg && xsg_n) begin
      exp_meas  = cyc - t_sub_rise;
      sub_last  = nsub;
      nsub      = 0;
      if (cyc - t_xsg_fall != XW) width_bad = width_bad + 1;
      xsg_rises = xsg_rises + 1;
    end
    if (wen) wen_acc = wen_acc + 1;
    p_xsub = xsub_n;
    p_xsg  = xsg_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_xsg(input int n);
    for (int k = 0; k < n; k++) begin
      int start;
      int g;
      start = xsg_rises;
      g = 0;
      while (xsg_rises == start && g < 6000) begin
        @(negedge clk);
        g++;
      end
      if (g >= 6000) check(1'b0, "R2", g, 0);
    end
  endtask

  function automatic int clamp_lines(input int n);
    if (n < 2) return 2;
    if (n > FL - 2) return FL - 2;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nc;
    int bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset levels
    check(xsub_n == 1'b1, "R1", int'(xsub_n), 1);
    check(xsg_n == 1'b1, "R1", int'(xsg_n), 1);
    check(wen == 1'b0, "R1", int'(wen), 0);

    // R7 shutter off
    shut_mode = 2'd0;
    wait_xsg(3);
    check(interval == FRAME, "R7", interval, FRAME);
    check(sub_last == 0, "R7", sub_last, 0);

    // R5 / R6 line mode sweep including clamped counts
    shut_mode = 2'd1;
    for (int n = 0; n < 12; n++) begin
      exp_count = CW'(n);
      wait_xsg(3);
      nc = clamp_lines(n);
      check(exp_meas == nc * LC + TAIL, (n < 2 || n > FL - 2) ? "R6" : "R5",
            exp_meas, nc * LC + TAIL);
      check(sub_last == FL - nc, "R5", sub_last, FL - nc);
    end
    check(interval == FRAME, "R2", interval, FRAME);

    // R8 flickerless
    shut_mode = 2'd3;
    exp_count = CW'(2);
    wait_xsg(3);
    check(exp_meas == (FL * 3 / 5) * LC + TAIL, "R8", exp_meas, (FL * 3 / 5) * LC + TAIL);

    // R10 count written mid-frame
    shut_mode = 2'd1;
    exp_count = CW'(4);
    wait_xsg(3);
    while (xsg_n) @(negedge clk);
    repeat (2 * LC) @(negedge clk);
    exp_count = CW'(2);
    wait_xsg(1);
    check(sub_last == FL - 4, "R10", sub_last, FL - 4);
    check(exp_meas == 4 * LC + TAIL, "R10", exp_meas, 4 * LC + TAIL);
    wait_xsg(1);
    check(exp_meas == 2 * LC + TAIL, "R10", exp_meas, 2 * LC + TAIL);

    // R11 / R12 line flag modes
    exp_count = CW'(4);
    wm = 1'b0;
    wait_xsg(3);
    check(wen_last == (VL - VF + 1) * LC, "R11", wen_last, (VL - VF + 1) * LC);
    wm = 1'b1;
    wait_xsg(3);
    check(wen_last == FRAME - XPOS, "R12", wen_last, FRAME - XPOS);
    wm = 1'b0;

    // R3 vertical sync outside window
    shut_mode = 2'd0;
    glitch_en = 1'b1;
    wait_xsg(3);
    check(interval == FRAME, "R3", interval, FRAME);
    glitch_en = 1'b0;

    // R9 frame mode, including clamp of low counts
    shut_mode = 2'd2;
    for (int f = 0; f < 5; f++) begin
      int fe;
      exp_count = CW'(f);
      fe = (f < 2) ? 2 : f;
      wait_xsg(3);
      check(interval == fe * FRAME, "R9", interval, fe * FRAME);
      check(sub_last == 0, "R9", sub_last, 0);
    end

    // R4 pulse width over the whole run so far
    check(width_bad == 0, "R4", width_bad, 0);

    // R13 standby cutting a live readout pulse
    shut_mode = 2'd1;
    exp_count = CW'(4);
    wm = 1'b1;
    wait_xsg(2);
    while (xsg_n) @(negedge clk);
    stdby_n = 1'b0;
    @(negedge clk);
    check(xsg_n == 1'b1, "R13", int'(xsg_n), 1);
    bad = 0;
    repeat (2 * FRAME) begin
      @(negedge clk);
      if (!xsub_n || !xsg_n || wen) bad++;
    end
    check(bad == 0, "R13", bad, 0);
    stdby_n = 1'b1;
    wait_xsg(3);
    check(exp_meas == 4 * LC + TAIL, "R13", exp_meas, 4 * LC + TAIL);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule